// File: doc/BRIEF.md
# Two-Dimensional 5/3 Lifting Wavelet Engine

This block computes one level of a separable two-dimensional integer wavelet transform over a square image of N×N unsigned pixels. N is a parameter and must be a power of two, at least 4. Pixels arrive two per cycle, as an even/odd column pair of the same row, in row-major order. A line-lifting unit turns each row into N/2 smooth coefficients and N/2 detail coefficients. The unit computes both coefficients of one index in the same cycle. Both ports of a dual-port coefficient store write each pair side by side.

Once the final row coefficient has been written, the same store is read column-wise through both ports at once: an even row and an odd row of one column per cycle. A second instance of the same lifting unit transforms each column. The vertically filtered results leave on two paired streams. Stream A carries the vertical-detail bands (LH, HH). Stream B carries the vertical-smooth bands (LL, HL). Each output word carries a band code and its row and column inside that band.

A controller orders a single start pulse, the load phase, the column phase and a final done pulse. Recursion on the LL band is left to the surrounding logic.

Top module: `dwt2d_engine`

## Requirements
- R1: After reset, `busy`, `done`, `a_valid` and `b_valid` are all low.
- R2: `start` is taken only while `busy` is low. A `start` pulse seen while `busy` is high changes neither the results nor the number of outputs, and adds no extra `done`.
- R3: After an accepted start, the next N·N/2 cycles with `pix_valid` high load the image. Each such cycle takes the pixel at column 2k on `pix_even` and the pixel at column 2k+1 on `pix_odd`, walking k across a row and then down the rows. Cycles with `pix_valid` low are skipped.
- R4: Each row x of length N is lifted as d[i] = x[2i+1] − floor((x[2i] + x[2i+2]) / 2), then s[i] = x[2i] + floor((d[i−1] + d[i] + 2) / 4). At the edges, x[N] is taken as x[N−2] and d[−1] as d[0].
- R5: Column filtering reads only after every row coefficient has been stored. Row smooth terms sit in columns 0..N/2−1 and row detail terms in columns N/2..N−1. The same lifting is applied down each column of that array.
- R6: Band code bit 1 is 1 for vertical detail, and bit 0 is 1 for horizontal detail: 00 = LL, 01 = HL, 10 = LH, 11 = HH. The row field is the vertical index j. The column field is the stored column modulo N/2.
- R7: `a_valid` and `b_valid` rise in the same cycles, and each stream carries N·N/2 words per image. Words come out column by column, stored columns 0 to N−1, with j ascending within a column. A carries the vertical detail of a position and B the vertical smooth of the same position.
- R8: `done` is a one-cycle pulse in the cycle after the final output word, and `busy` is low in that cycle.
- R9: A flat image of value v yields v everywhere in LL and zero in HL, LH and HH, including at the image borders.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new image (idle only) |
| pix_valid | input | 1 | Pixel pair present |
| pix_even | input | PIX_W | Pixel at even column |
| pix_odd | input | PIX_W | Pixel at odd column |
| busy | output | 1 | Engine occupied with an image |
| done | output | 1 | One-cycle end-of-image pulse |
| a_valid | output | 1 | Stream A word present |
| a_band | output | 2 | Band code of stream A word (LH or HH) |
| a_row | output | log2(N/2) | Row inside band |
| a_col | output | log2(N/2) | Column inside band |
| a_data | output | PIX_W+5 | Signed coefficient, stream A |
| b_valid | output | 1 | Stream B word present |
| b_band | output | 2 | Band code of stream B word (LL or HL) |
| b_row | output | log2(N/2) | Row inside band |
| b_col | output | log2(N/2) | Column inside band |
| b_data | output | PIX_W+5 | Signed coefficient, stream B |

## Verification
Several properties are checked on every clock. The first is that no column read is issued before all row pairs are written. The others are that output words appear only in the column or drain phase, that a late start never reopens the load phase, and that `done` follows an output word and lasts one cycle. A further check is that a line's flush never meets the next pair of that line. The coefficient values, the edge mirroring and the band ordering are shown only by the bench's scenarios. These compare every band word against an independent array model for ramp, flat, pseudo-random, checkerboard and product images, with and without gaps in the pixel stream.

// File: rtl/dwt_pkg.sv
package dwt_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int CALC_W = 20;
  typedef logic signed [CALC_W-1:0] calc_t;

  typedef enum logic [1:0] {
    BAND_LL = 2'b00,
    BAND_HL = 2'b01,
    BAND_LH = 2'b10,
    BAND_HH = 2'b11
  } band_e;

  // detail term: odd sample minus floor of the mean of its even neighbours
  function automatic calc_t lift_predict(calc_t odd_s, calc_t ev_l, calc_t ev_r);
    calc_t sum;
    sum = ev_l + ev_r;
    return odd_s - (sum >>> 1);
  endfunction

  // smooth term: even sample plus rounded quarter of the two details around it
  function automatic calc_t lift_update(calc_t ev, calc_t d_l, calc_t d_r);
    calc_t sum;
    sum = d_l + d_r + calc_t'(2);
    return ev + (sum >>> 2);
  endfunction
endpackage

// File: rtl/dwt_lift53_line.sv
module dwt_lift53_line import dwt_pkg::*; #(
  parameter int IW = 9,
  parameter int OW = 11,
  parameter int TW = 3,
  parameter int NP = 4,
  localparam int XW = (NP > 1) ? $clog2(NP) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_vld,
  input  logic                 in_first,
  input  logic                 in_last,
  input  logic signed [IW-1:0] in_even,
  input  logic signed [IW-1:0] in_odd,
  input  logic [TW-1:0]        in_tag,
  output logic                 out_vld,
  output logic signed [OW-1:0] out_lo,
  output logic signed [OW-1:0] out_hi,
  output logic [TW-1:0]        out_tag,
  output logic [XW-1:0]        out_idx
);
  timeunit 1ns;
  timeprecision 1ps;

  logic signed [IW-1:0] ev_q, od_q;
  logic signed [OW-1:0] dp_q;
  logic [TW-1:0]        tag_q;
  logic [XW-1:0]        idx_q;
  logic                 flush_q;

  // the held pair is completed either by the next even sample or by a flush
  logic fire;
  assign fire = flush_q | (in_vld & ~in_first);

  calc_t ev_c, od_c, evr_c, d_c, dl_c, s_c;
  always_comb begin
    ev_c  = calc_t'(ev_q);
    od_c  = calc_t'(od_q);
    evr_c = flush_q ? ev_c : calc_t'(in_even);
    d_c   = lift_predict(od_c, ev_c, evr_c);
    dl_c  = (idx_q == '0) ? d_c : calc_t'(dp_q);
    s_c   = lift_update(ev_c, dl_c, d_c);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ev_q    <= '0;
      od_q    <= '0;
      dp_q    <= '0;
      tag_q   <= '0;
      idx_q   <= '0;
      flush_q <= 1'b0;
      out_vld <= 1'b0;
      out_lo  <= '0;
      out_hi  <= '0;
      out_tag <= '0;
      out_idx <= '0;
    end else begin
      flush_q <= in_vld & in_last;
      if (in_vld) begin
        ev_q  <= in_even;
        od_q  <= in_odd;
        tag_q <= in_tag;
        idx_q <= in_first ? '0 : idx_q + 1'b1;
      end
      out_vld <= fire;
      if (fire) begin
        dp_q    <= d_c[OW-1:0];
        out_lo  <= s_c[OW-1:0];
        out_hi  <= d_c[OW-1:0];
        out_tag <= tag_q;
        out_idx <= idx_q;
      end
    end
  end

  AST_FLUSH_NOT_OVERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    flush_q |-> !(in_vld && !in_first)); // R4
endmodule

// File: rtl/dwt_tpose_ram.sv
module dwt_tpose_ram #(
  parameter int DW = 11,
  parameter int DEPTH = 64,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          pa_we,
  input  logic [AW-1:0] pa_addr,
  input  logic [DW-1:0] pa_wd,
  output logic [DW-1:0] pa_rd,
  input  logic          pb_we,
  input  logic [AW-1:0] pb_addr,
  input  logic [DW-1:0] pb_wd,
  output logic [DW-1:0] pb_rd
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (pa_we) mem[pa_addr] <= pa_wd;
    if (pb_we) mem[pb_addr] <= pb_wd;
    pa_rd <= mem[pa_addr];
    pb_rd <= mem[pb_addr];
  end
endmodule

// File: rtl/dwt2d_engine.sv
module dwt2d_engine import dwt_pkg::*; #(
  parameter int PIX_W = 8,
  parameter int N = 8,
  localparam int HW = $clog2(N/2),
  localparam int DW = PIX_W + 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_even,
  input  logic [PIX_W-1:0] pix_odd,
  output logic             busy,
  output logic             done,
  output logic             a_valid,
  output logic [1:0]       a_band,
  output logic [HW-1:0]    a_row,
  output logic [HW-1:0]    a_col,
  output logic [DW-1:0]    a_data,
  output logic             b_valid,
  output logic [1:0]       b_band,
  output logic [HW-1:0]    b_row,
  output logic [HW-1:0]    b_col,
  output logic [DW-1:0]    b_data
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int HALF  = N / 2;
  localparam int LW    = $clog2(N);
  localparam int AW    = 2 * LW;
  localparam int RIW   = PIX_W + 1;
  localparam int RCW   = PIX_W + 3;
  localparam int PAIRS = N * HALF;

  typedef enum logic [2:0] {S_IDLE, S_ROW, S_ROWFIN, S_COL, S_DRAIN} st_e;
  st_e st_q;

  logic [LW-1:0] prow_q, ccol_q;
  logic [HW-1:0] pk_q, cj_q;
  logic [AW:0]   wr_cnt_q;

  // named events for the controller and the assertions
  logic pix_take, pk_end, cj_end, col_rd, row_last_wr, col_last_out;
  assign pix_take = (st_q == S_ROW) && pix_valid;
  assign pk_end   = pk_q == HW'(HALF - 1);
  assign cj_end   = cj_q == HW'(HALF - 1);
  assign col_rd   = st_q == S_COL;

  // ---------------- row processor ----------------
  logic signed [RIW-1:0] px_e, px_o;
  assign px_e = {1'b0, pix_even};
  assign px_o = {1'b0, pix_odd};

  logic                  r_vld;
  logic signed [RCW-1:0] r_lo, r_hi;
  logic [LW-1:0]         r_tag;
  logic [HW-1:0]         r_idx;

  dwt_lift53_line #(.IW(RIW), .OW(RCW), .TW(LW), .NP(HALF)) u_row (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (pix_take),
    .in_first (pk_q == '0),
    .in_last  (pk_end),
    .in_even  (px_e),
    .in_odd   (px_o),
    .in_tag   (prow_q),
    .out_vld  (r_vld),
    .out_lo   (r_lo),
    .out_hi   (r_hi),
    .out_tag  (r_tag),
    .out_idx  (r_idx)
  );

  assign row_last_wr = r_vld && (r_tag == LW'(N - 1)) && (r_idx == HW'(HALF - 1));

  // ---------------- transposing store ----------------
  logic [AW-1:0]  pa_addr, pb_addr;
  logic [RCW-1:0] pa_rd, pb_rd;

  // row write: row r, column k (smooth) and N/2+k (detail)
  // column read: rows 2j and 2j+1 of one column
  assign pa_addr = col_rd ? {cj_q, 1'b0, ccol_q} : {r_tag, 1'b0, r_idx};
  assign pb_addr = col_rd ? {cj_q, 1'b1, ccol_q} : {r_tag, 1'b1, r_idx};

  dwt_tpose_ram #(.DW(RCW), .DEPTH(N * N)) u_ram (
    .clk     (clk),
    .pa_we   (r_vld),
    .pa_addr (pa_addr),
    .pa_wd   (r_lo),
    .pa_rd   (pa_rd),
    .pb_we   (r_vld),
    .pb_addr (pb_addr),
    .pb_wd   (r_hi),
    .pb_rd   (pb_rd)
  );

  // ---------------- column processor ----------------
  logic          rdv_q, rdf_q, rdl_q;
  logic [LW-1:0] rdt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdv_q <= 1'b0;
      rdf_q <= 1'b0;
      rdl_q <= 1'b0;
      rdt_q <= '0;
    end else begin
      rdv_q <= col_rd;
      rdf_q <= cj_q == '0;
      rdl_q <= cj_end;
      rdt_q <= ccol_q;
    end
  end

  logic signed [RCW-1:0] ce, co;
  assign ce = pa_rd;
  assign co = pb_rd;

  logic                 c_vld;
  logic signed [DW-1:0] c_lo, c_hi;
  logic [LW-1:0]        c_tag;
  logic [HW-1:0]        c_idx;

  dwt_lift53_line #(.IW(RCW), .OW(DW), .TW(LW), .NP(HALF)) u_col (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (rdv_q),
    .in_first (rdf_q),
    .in_last  (rdl_q),
    .in_even  (ce),
    .in_odd   (co),
    .in_tag   (rdt_q),
    .out_vld  (c_vld),
    .out_lo   (c_lo),
    .out_hi   (c_hi),
    .out_tag  (c_tag),
    .out_idx  (c_idx)
  );

  assign col_last_out = c_vld && (c_tag == LW'(N - 1)) && (c_idx == HW'(HALF - 1));

  // ---------------- output streams ----------------
  assign a_valid = c_vld;
  assign a_band  = {1'b1, c_tag[LW-1]};
  assign a_row   = c_idx;
  assign a_col   = c_tag[HW-1:0];
  assign a_data  = c_hi;
  assign b_valid = c_vld;
  assign b_band  = {1'b0, c_tag[LW-1]};
  assign b_row   = c_idx;
  assign b_col   = c_tag[HW-1:0];
  assign b_data  = c_lo;

  assign busy = st_q != S_IDLE;

  // ---------------- controller ----------------
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      prow_q <= '0;
      pk_q   <= '0;
      ccol_q <= '0;
      cj_q   <= '0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st_q)
        S_IDLE: if (start) begin
          st_q   <= S_ROW;
          prow_q <= '0;
          pk_q   <= '0;
        end
        S_ROW: if (pix_valid) begin
          pk_q <= pk_q + 1'b1;
          if (pk_end) begin
            pk_q   <= '0;
            prow_q <= prow_q + 1'b1;
            if (prow_q == LW'(N - 1)) st_q <= S_ROWFIN;
          end
        end
        S_ROWFIN: if (row_last_wr) begin
          st_q   <= S_COL;
          ccol_q <= '0;
          cj_q   <= '0;
        end
        S_COL: begin
          cj_q <= cj_q + 1'b1;
          if (cj_end) begin
            cj_q   <= '0;
            ccol_q <= ccol_q + 1'b1;
            if (ccol_q == LW'(N - 1)) st_q <= S_DRAIN;
          end
        end
        S_DRAIN: if (col_last_out) begin
          st_q <= S_IDLE;
          done <= 1'b1;
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  // count of stored row pairs, kept for the ordering assertion
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_cnt_q <= '0;
    else if (st_q == S_IDLE && start) wr_cnt_q <= '0;
    else if (r_vld) wr_cnt_q <= wr_cnt_q + 1'b1;
  end

  AST_COL_AFTER_ROWS: assert property (@(posedge clk) disable iff (!rst_n)
    col_rd |-> wr_cnt_q == (AW+1)'(PAIRS)); // R5
  AST_OUT_IN_COL_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
    c_vld |-> (st_q == S_COL || st_q == S_DRAIN)); // R7
  AST_LATE_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st_q != S_IDLE && st_q != S_ROW) |=> st_q != S_ROW); // R2
  AST_ROW_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && st_q == S_ROW && !pix_valid) |=> $stable({prow_q, pk_q})); // R2
  AST_DONE_FOLLOWS_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(c_vld) && !busy); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
endmodule

// File: tb/tb_dwt2d_engine.sv
module tb_dwt2d_engine;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int PW = 8;
  localparam int N  = 8;
  localparam int H  = N / 2;
  localparam int HB = $clog2(H);
  localparam int DW = PW + 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic pix_valid = 1'b0;
  logic [PW-1:0] pix_even = '0, pix_odd = '0;
  logic busy, done, a_valid, b_valid;
  logic [1:0] a_band, b_band;
  logic [HB-1:0] a_row, a_col, b_row, b_col;
  logic [DW-1:0] a_data, b_data;

  always #4 clk = ~clk;

  dwt2d_engine #(.PIX_W(PW), .N(N)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .pix_valid(pix_valid),
    .pix_even(pix_even), .pix_odd(pix_odd), .busy(busy), .done(done),
    .a_valid(a_valid), .a_band(a_band), .a_row(a_row), .a_col(a_col), .a_data(a_data),
    .b_valid(b_valid), .b_band(b_band), .b_row(b_row), .b_col(b_col), .b_data(b_data)
  );

  int errors = 0;
  int checks = 0;
  int img [N][N];
  int mid [N][N];
  int expb [4][H][H];
  int gotb [4][H][H];
  int line_x [N];
  int line_s [H];
  int line_d [H];
  int n_out, seq_c, seq_j;
  bit mon_on = 1'b0;
  int unsigned lfsr = 32'h1D2C3B4A;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // array-level lifting of line_x into line_s / line_d
  task automatic ref_line();
    for (int i = 0; i < H; i++) begin
      int right;
      right = (2*i + 2 < N) ? line_x[2*i + 2] : line_x[2*i];
      line_d[i] = line_x[2*i + 1] - ((line_x[2*i] + right) >>> 1);
    end
    for (int i = 0; i < H; i++) begin
      int left;
      left = (i == 0) ? line_d[0] : line_d[i - 1];
      line_s[i] = line_x[2*i] + ((left + line_d[i] + 2) >>> 2);
    end
  endtask

  task automatic ref_image();
    for (int r = 0; r < N; r++) begin
      for (int c = 0; c < N; c++) line_x[c] = img[r][c];
      ref_line();
      for (int i = 0; i < H; i++) begin
        mid[r][i] = line_s[i];
        mid[r][H + i] = line_d[i];
      end
    end
    for (int c = 0; c < N; c++) begin
      for (int r = 0; r < N; r++) line_x[r] = mid[r][c];
      ref_line();
      for (int j = 0; j < H; j++) begin
        expb[(c >= H) ? 1 : 0][j][c % H] = line_s[j];
        expb[(c >= H) ? 3 : 2][j][c % H] = line_d[j];
      end
    end
  endtask

  // output monitor: pairing, order and band tagging of every word
  always @(negedge clk) begin
    if (mon_on && (a_valid || b_valid)) begin
      chk(a_valid == b_valid, "R7", "stream valids paired", int'(a_valid), int'(b_valid));
      chk(a_row == b_row && a_col == b_col && a_band[0] == b_band[0] &&
          a_band[1] == 1'b1 && b_band[1] == 1'b0, "R6", "band tags of A/B",
          int'(a_band) * 4 + int'(b_band), ((seq_c >= H) ? 1 : 0) * 5 + 8);
      chk(int'(a_row) == seq_j && int'(a_col) == seq_c % H &&
          int'(a_band[0]) == ((seq_c >= H) ? 1 : 0), "R7", "word order (col*16+row)",
          (int'(a_band[0]) * H + int'(a_col)) * 16 + int'(a_row), seq_c * 16 + seq_j);
      gotb[a_band][a_row][a_col] = int'($signed(a_data));
      gotb[b_band][b_row][b_col] = int'($signed(b_data));
      n_out++;
      seq_j++;
      if (seq_j == H) begin
        seq_j = 0;
        seq_c++;
      end
    end
  end

  task automatic fill_image(input int kind);
    for (int r = 0; r < N; r++)
      for (int c = 0; c < N; c++) begin
        case (kind)
          0: img[r][c] = (r * 20 + c * 9) % 256;
          1: img[r][c] = 200;
          2: begin
            lfsr = lfsr * 32'd1103515245 + 32'd12345;
            img[r][c] = int'((lfsr >> 16) & 32'hFF);
          end
          3: img[r][c] = ((r + c) % 2 == 1) ? 255 : 0;
          default: img[r][c] = (r * c * 37 + r) % 256;
        endcase
      end
  endtask

  // one image: load, optional gaps, optional starts while busy, then full comparison
  task automatic run_image(input int kind, input int gap, input bit inject, input string req);
    bit seen;
    fill_image(kind);
    ref_image();
    for (int b = 0; b < 4; b++)
      for (int j = 0; j < H; j++)
        for (int c = 0; c < H; c++) gotb[b][j][c] = -99999;
    n_out = 0; seq_c = 0; seq_j = 0; mon_on = 1'b1;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2", "busy after idle start", int'(busy), 1);
    for (int r = 0; r < N; r++)
      for (int k = 0; k < H; k++) begin
        if (gap > 0 && ((r * H + k) % gap) == gap - 1) begin
          pix_valid = 1'b0;
          pix_even = 8'hAA;
          pix_odd = 8'h55;
          @(negedge clk);
        end
        pix_valid = 1'b1;
        pix_even = PW'(img[r][2*k]);
        pix_odd  = PW'(img[r][2*k + 1]);
        start = inject && r == 2 && k == 1;
        @(negedge clk);
      end
    pix_valid = 1'b0;
    start = 1'b0;
    if (inject) begin
      repeat (8) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, "R2", "busy kept after late start", int'(busy), 1);
    end
    seen = 1'b0;
    for (int t = 0; t < 400 && !seen; t++) begin
      if (done) seen = 1'b1;
      else @(negedge clk);
    end
    chk(seen, "R8", "done pulse seen", int'(seen), 1);
    chk(n_out == N * H, "R8", "words before done", n_out, N * H);
    chk(busy == 1'b0, "R8", "busy low with done", int'(busy), 0);
    @(negedge clk);
    chk(done == 1'b0, "R8", "done lasts one cycle", int'(done), 0);
    repeat (10) @(negedge clk);
    chk(n_out == N * H, "R7", "words per stream", n_out, N * H);
    chk(busy == 1'b0, "R2", "no restart after image", int'(busy), 0);
    for (int b = 0; b < 4; b++)
      for (int j = 0; j < H; j++)
        for (int c = 0; c < H; c++)
          chk(gotb[b][j][c] == expb[b][j][c], req,
              $sformatf("band %0d row %0d col %0d", b, j, c), gotb[b][j][c], expb[b][j][c]);
    mon_on = 1'b0;
  endtask

  task automatic check_reset();
    chk(busy == 1'b0, "R1", "busy at reset", int'(busy), 0);
    chk(done == 1'b0, "R1", "done at reset", int'(done), 0);
    chk(a_valid == 1'b0 && b_valid == 1'b0, "R1", "valids at reset",
        int'(a_valid) + int'(b_valid), 0);
  endtask

  task automatic check_flat();
    int bad;
    bad = 0;
    for (int j = 0; j < H; j++)
      for (int c = 0; c < H; c++) begin
        if (gotb[0][j][c] != 200) bad++;
        if (gotb[1][j][c] != 0 || gotb[2][j][c] != 0 || gotb[3][j][c] != 0) bad++;
      end
    chk(bad == 0, "R9", "flat image band pattern mismatches", bad, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check_reset();
    run_image(0, 0, 1'b0, "R4");
    run_image(1, 0, 1'b0, "R9");
    check_flat();
    run_image(2, 3, 1'b0, "R3");
    run_image(3, 0, 1'b1, "R2");
    run_image(4, 5, 1'b0, "R5");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule